// File: doc/BRIEF.md
# Byte-stream command register file

This block keeps eight byte-wide registers and is driven entirely by a byte stream. It is meant to sit between a serial receiver and a serial transmitter. Every transaction opens with a header byte. The header packs a register index and an operation code. A write header is followed by exactly one payload byte, which is stored in the register the header selected. A read header makes the block return the selected register's current value as a single byte on the output stream.

Index 0 holds a fixed version constant, set by a parameter. Writes aimed at index 0 are consumed from the stream but have no effect. Headers that carry an unknown operation are discarded without a reply. Both streams use a valid/ready handshake. Input is stalled while a reply waits on the output, so replies always come back in the order of the requests.

Top module: `byte_cmd_regfile`

## Requirements
- R1: After reset is released, `s_ready_o` is 1, `m_valid_o` is 0, indices 1 to 7 read back 0x00 and index 0 reads back `VERSION`.
- R2: A header with bits [3:0] = 0x0 (read) and bits [6:4] = index, accepted in one cycle, raises `m_valid_o` in the next cycle with `m_data_o` equal to that register's value.
- R3: A header with bits [3:0] = 0x1 (write) makes the next accepted input byte the payload, and that payload is stored at the index in bits [6:4]. A write produces no output byte.
- R4: Index 0 always reads `VERSION`. A write to index 0 consumes both of its bytes and changes nothing.
- R5: A header whose bits [3:0] are neither 0x0 nor 0x1 is dropped with no reply, and the byte after it is parsed as a new header.
- R6: Bit 7 of the header is ignored. It affects neither the index nor the operation.
- R7: While `m_valid_o` is 1 and `m_ready_i` is 0, `m_valid_o` and `m_data_o` hold their values and `s_ready_o` stays 0.
- R8: An input byte moves only in a cycle where `s_valid_i` and `s_ready_o` are both 1. Data presented with `s_valid_i` at 0 has no effect.
- R9: A read header that directly follows a write payload, in the next cycle, returns the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | 8 | Input stream byte (header or payload) |
| s_valid_i | input | 1 | Input byte is valid |
| s_ready_o | output | 1 | Block can accept an input byte |
| m_data_o | output | 8 | Reply byte |
| m_valid_o | output | 1 | Reply byte is valid |
| m_ready_i | input | 1 | Consumer accepts the reply byte |

## Verification
A parser stuck in the payload phase shows up as a swallowed header: the next read returns nothing, and the reply timeout exposes it within a few cycles. A parser stuck in the reply phase shows up as `s_ready_o` staying low. A bad index decode or a storage fault shows up at the next read of the affected register, as a wrong reply byte compared against the bench's shadow copy. The bench uses back-to-back transfers and held-off replies so that ordering and stall faults appear within the cycle they occur.

// File: rtl/rfcmd_pkg.sv
package rfcmd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned NREG   = 1 << IDX_W;
  localparam int unsigned OP_W   = 4;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam logic [OP_W-1:0] OP_RD = 4'h0;
  localparam logic [OP_W-1:0] OP_WR = 4'h1;

  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_PAY = 2'd1,
    PH_RSP = 2'd2
  } phase_e;
endpackage

// File: rtl/rfcmd_store.sv
module rfcmd_store
  import rfcmd_pkg::*;
#(
  parameter byte_t VERSION = 8'hA5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  idx_t  wr_idx_i,
  input  byte_t wr_data_i,
  input  idx_t  rd_idx_i,
  output byte_t rd_data_o
);
  byte_t regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_ver
      assign regs[g] = VERSION;
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    regs[g] <= '0;
        else if (wr_en_i && wr_idx_i == idx_t'(g))      regs[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = regs[rd_idx_i];
endmodule

// File: rtl/rfcmd_parser.sv
module rfcmd_parser
  import rfcmd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  byte_t s_data_i,
  input  logic  s_valid_i,
  output logic  s_ready_o,
  output byte_t m_data_o,
  output logic  m_valid_o,
  input  logic  m_ready_i,
  output logic  wr_en_o,
  output idx_t  wr_idx_o,
  output byte_t wr_data_o,
  output idx_t  rd_idx_o,
  input  byte_t rd_data_i,
  output logic  hdr_phase_o
);
  phase_e phase_q, phase_d;
  idx_t   idx_q;
  byte_t  rsp_q;
  logic   s_fire;
  logic [OP_W-1:0] op;
  idx_t   hdr_idx;

  assign op        = s_data_i[OP_W-1:0];
  assign hdr_idx   = s_data_i[OP_W +: IDX_W]; // bit 7 unused
  assign s_ready_o = (phase_q != PH_RSP);
  assign s_fire    = s_valid_i && s_ready_o;
  assign m_valid_o = (phase_q == PH_RSP);
  assign m_data_o  = rsp_q;
  assign rd_idx_o  = hdr_idx;
  assign hdr_phase_o = (phase_q == PH_HDR);

  // index 0 is filtered here so storage never sees it
  assign wr_en_o   = (phase_q == PH_PAY) && s_fire && (idx_q != '0);
  assign wr_idx_o  = idx_q;
  assign wr_data_o = s_data_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_HDR: if (s_fire) begin
        if (op == OP_RD)      phase_d = PH_RSP;
        else if (op == OP_WR) phase_d = PH_PAY;
      end
      PH_PAY: if (s_fire)    phase_d = PH_HDR;
      PH_RSP: if (m_ready_i) phase_d = PH_HDR;
      default:               phase_d = PH_HDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HDR;
      idx_q   <= '0;
      rsp_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_HDR && s_fire) begin
        idx_q <= hdr_idx;
        if (op == OP_RD) rsp_q <= rd_data_i;
      end
    end
  end
endmodule

// File: rtl/byte_cmd_regfile.sv
module byte_cmd_regfile
  import rfcmd_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'hA5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  output logic       s_ready_o,
  output logic [7:0] m_data_o,
  output logic       m_valid_o,
  input  logic       m_ready_i
);
  logic  wr_en;
  idx_t  wr_idx, rd_idx;
  byte_t wr_data, rd_data;
  logic  hdr_phase;

  rfcmd_parser u_parser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .s_data_i   (s_data_i),
    .s_valid_i  (s_valid_i),
    .s_ready_o  (s_ready_o),
    .m_data_o   (m_data_o),
    .m_valid_o  (m_valid_o),
    .m_ready_i  (m_ready_i),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_idx_o   (rd_idx),
    .rd_data_i  (rd_data),
    .hdr_phase_o(hdr_phase)
  );

  rfcmd_store #(.VERSION(VERSION)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data)
  );
endmodule

// File: rtl/rfcmd_chk.sv
module rfcmd_chk #(
  parameter logic [7:0] VERSION = 8'hA5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] s_data_i,
  input logic       s_valid_i,
  input logic       s_ready_o,
  input logic [7:0] m_data_o,
  input logic       m_valid_o,
  input logic       m_ready_i,
  input logic       hdr_phase
);
  logic rd_hdr_fire;
  assign rd_hdr_fire = hdr_phase && s_valid_i && s_ready_o && s_data_i[3:0] == 4'h0;

  // R7
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o));

  // R7
  in_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> !s_ready_o);

  // R2
  rd_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hdr_fire |=> m_valid_o);

  // R4
  version_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hdr_fire && s_data_i[6:4] == 3'd0 |=> m_data_o == VERSION);

  // R8
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_valid_o && !(s_valid_i && s_ready_o) |=> !m_valid_o);
endmodule

bind byte_cmd_regfile rfcmd_chk #(.VERSION(VERSION)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .s_data_i (s_data_i),
  .s_valid_i(s_valid_i),
  .s_ready_o(s_ready_o),
  .m_data_o (m_data_o),
  .m_valid_o(m_valid_o),
  .m_ready_i(m_ready_i),
  .hdr_phase(hdr_phase)
);

// File: tb/byte_cmd_regfile_bench.sv
module byte_cmd_regfile_bench;
  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] VER        = 8'h5C;
  localparam int         NVEC       = 8;
  // {index[2:0], write data[7:0], expected read[7:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd1, 8'h3C, 8'h3C},
    {3'd7, 8'hFF, 8'hFF},
    {3'd2, 8'h00, 8'h00},
    {3'd0, 8'h5A, VER},
    {3'd4, 8'h81, 8'h81},
    {3'd1, 8'hC3, 8'hC3},
    {3'd6, 8'h7E, 8'h7E},
    {3'd3, 8'h11, 8'h11}
  };

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic [7:0] s_data_i = 0;
  logic       s_valid_i = 0;
  logic       s_ready_o;
  logic [7:0] m_data_o;
  logic       m_valid_o;
  logic       m_ready_i = 0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  byte_cmd_regfile #(.VERSION(VER)) u_byte_cmd_regfile (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // drive one byte; valid stays high until the caller idles
  task automatic put(logic [7:0] b);
    s_data_i  = b;
    s_valid_i = 1;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    s_valid_i = 0;
  endtask

  task automatic wr(logic [2:0] idx, logic [7:0] d, logic b7 = 0);
    put({b7, idx, 4'h1});
    put(d);
  endtask

  // issue read header, take reply with ready high
  task automatic rd(logic [2:0] idx, output logic [7:0] d, input logic b7 = 0);
    put({b7, idx, 4'h0});
    idle();
    d = 8'hxx;
    for (int i = 0; i < 8; i++) begin
      if (m_valid_o) begin
        d = m_data_o;
        break;
      end
      @(negedge clk_i);
    end
    m_ready_i = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    m_ready_i = 0;
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 ready", {7'd0, s_ready_o}, 8'd1);
    chk("R1 valid", {7'd0, m_valid_o}, 8'd0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      chk("R1 reset value", d, (i == 0) ? VER : 8'h00);
    end

    // R3 R4 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      idle();
      chk("R3 no reply to write", {7'd0, m_valid_o}, 8'd0);
      rd(VEC[i][18:16], d);
      chk("R2 R3 R4 read back", d, VEC[i][7:0]);
    end

    // R9 back-to-back write then read
    put(8'h51); put(8'hE7); put(8'h50);
    idle();
    chk("R9 reply valid", {7'd0, m_valid_o}, 8'd1);
    chk("R9 fresh value", m_data_o, 8'hE7);

    // R7 hold-off
    s_data_i = 8'h20; s_valid_i = 1; // pending read of index 2, must not be taken
    repeat (4) begin
      @(negedge clk_i);
      chk("R7 valid held", {7'd0, m_valid_o}, 8'd1);
      chk("R7 data held", m_data_o, 8'hE7);
      chk("R7 input stalled", {7'd0, s_ready_o}, 8'd0);
    end
    m_ready_i = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    m_ready_i = 0;
    // the stalled header is taken in this cycle
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
    chk("R7 queued read", m_data_o, 8'h00);
    chk("R7 queued valid", {7'd0, m_valid_o}, 8'd1);
    m_ready_i = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    m_ready_i = 0;

    // R8 data with valid low
    s_data_i = 8'h31; s_valid_i = 0;
    repeat (3) @(negedge clk_i);
    s_data_i = 8'h99;
    repeat (2) @(negedge clk_i);
    chk("R8 no reply", {7'd0, m_valid_o}, 8'd0);
    rd(3'd3, d);
    chk("R8 reg unchanged", d, 8'h11);

    // R5 unknown op then read header parsed fresh
    put(8'h35);
    idle();
    chk("R5 no reply", {7'd0, m_valid_o}, 8'd0);
    rd(3'd3, d);
    chk("R5 next byte is header", d, 8'h11);
    put(8'h3F);
    idle();
    rd(3'd6, d);
    chk("R5 op F dropped", d, 8'h7E);

    // R6 reserved bit
    wr(3'd5, 8'h6D, 1'b1);
    idle();
    rd(3'd5, d, 1'b1);
    chk("R6 b7 set", d, 8'h6D);
    rd(3'd5, d);
    chk("R6 b7 clear", d, 8'h6D);

    // R4 write to index 0 then neighbour untouched
    wr(3'd0, 8'h00);
    idle();
    rd(3'd0, d);
    chk("R4 version kept", d, VER);
    rd(3'd1, d);
    chk("R4 payload consumed", d, 8'hC3);

    // R1 mid-run reset
    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    rd(3'd1, d);
    chk("R1 cleared after reset", d, 8'h00);
    rd(3'd0, d);
    chk("R1 version after reset", d, VER);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule